// File: doc/BRIEF.md
# Class-Pair Issue Interlock

This block sits at the issue stage of a single in-order pipeline and decides, one cycle at a time, whether the instruction in front of it may go. Each cycle it may receive one decoded instruction: an operation class, one destination register with a write flag, and up to two source registers, each with its own valid bit. The block checks every used source against a table of outstanding results. If the producer of a source issued too recently, the block holds the instruction with a stall. Otherwise it raises a one-cycle issue pulse.

The number of cycles that must separate a producer from its consumer depends on both the producer's class and the consumer's class. A store's data operand needs fewer cycles than an ordinary source, because that operand is consumed later. Integer and floating-point registers share one 64-entry index space. The upstream stage holds the instruction, and every instruction behind it, for as long as stall is high. Each stall cycle sends one bubble down the pipeline.

Top module: `ilk_issue_top`

## Requirements
- R1: After reset no result is pending. With in_valid low both issue and stall are 0, and a valid instruction with no recent producer issues in the cycle it is presented.
- R2: Class codes are INT_ALU=0, INT_LOAD=1, FP_ALU=2, FP_LOAD=3, FP_STORE=4, BRANCH=5. An FP_ALU result read by an FP_ALU source needs 3 intervening cycles. With n idle cycles after the producer, the consumer stalls max(0, 3-n) cycles.
- R3: For an FP_STORE, src1 is the data operand. An FP_ALU result read there needs 2 intervening cycles, and read through the store's src0 (address) it needs 3.
- R4: An FP_LOAD result read by an FP_ALU source needs 1 intervening cycle.
- R5: An FP_LOAD result read as a store's data operand needs 0 intervening cycles.
- R6: An INT_LOAD result needs 1 intervening cycle before any dependent instruction. An INT_ALU result needs 0.
- R7: Register index 0 never creates a dependence, even when written. A source whose valid bit is 0 is ignored. Bit 5 set selects the FP bank, so index 32 is a real register.
- R8: issue and stall are never high together, and neither is high without in_valid. While an instruction waits, stall stays high every cycle and issue stays low, until the exact cycle its distance is met.
- R9: When a new producer writes a register that still has a pending entry, the new producer's class and issue time replace the old ones.
- R10: FP_STORE and BRANCH instructions never create a pending entry, and neither does an instruction with in_dst_we low.
- R11: Replaying the unscheduled vector-plus-scalar loop inserts 3 stall cycles per iteration. The scheduled, four-way unrolled version inserts none. Both counts match a model built from the same latency table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An instruction is presented |
| in_class | input | 3 | Operation class code |
| in_dst | input | 6 | Destination register index |
| in_dst_we | input | 1 | Instruction writes its destination |
| in_src0 | input | 6 | First source index (address for stores) |
| in_src0_v | input | 1 | First source is used |
| in_src1 | input | 6 | Second source index (data for stores) |
| in_src1_v | input | 1 | Second source is used |
| issue | output | 1 | Instruction issues this cycle |
| stall | output | 1 | Instruction held; bubble inserted |

## Verification
Wrong tracker state shows up at the ports as a stall count that is off by at least one cycle, on the first dependent instruction after the faulty entry. An age that fails to advance lengthens a stall. An entry that clears too early lets a consumer issue early, in the very cycle it is presented. An entry that is not replaced, or a role that is picked wrongly, changes the number of bubbles the next consumer sees. The directed tests therefore count stall cycles for each producer and consumer pair and for each idle gap, and the two loop replays compare whole-loop bubble totals.

// File: rtl/ilk_pkg.sv
// Package: shared class codes and sizing for the issue interlock.
// Assumes at most one instruction per cycle and a 64-entry register space.
package ilk_pkg;
    typedef enum logic [2:0] {
        CL_INT_ALU = 3'd0,
        CL_INT_LD  = 3'd1,
        CL_FP_ALU  = 3'd2,
        CL_FP_LD   = 3'd3,
        CL_FP_ST   = 3'd4,
        CL_BRANCH  = 3'd5
    } iclass_e;

    localparam int CLS_W   = 3;
    localparam int REG_W   = 6;
    localparam int NREG    = 1 << REG_W;
    localparam int MAX_GAP = 3;
    localparam int AGE_W   = $clog2(MAX_GAP + 2);

    // True when an instruction of this class produces a register result.
    function automatic logic cls_writes(input logic [CLS_W-1:0] c);
        return (c == CL_INT_ALU) || (c == CL_INT_LD) ||
               (c == CL_FP_ALU)  || (c == CL_FP_LD);
    endfunction
endpackage

// File: rtl/ilk_gap_lut.sv
// Latency lookup: gives the number of intervening cycles a consumer needs
// after a producer of class prod_cls. store_data selects the shorter
// distances that apply to a store's data operand.
module ilk_gap_lut
    import ilk_pkg::*;
(
    input  logic [CLS_W-1:0] prod_cls,
    input  logic             store_data,
    output logic [AGE_W-1:0] gap
);
    // Pick the distance from the producer class and the consumer role.
    always_comb begin
        unique case (prod_cls)
            CL_FP_ALU: gap = store_data ? AGE_W'(2) : AGE_W'(3);
            CL_FP_LD:  gap = store_data ? AGE_W'(0) : AGE_W'(1);
            CL_INT_LD: gap = AGE_W'(1);
            default:   gap = AGE_W'(0);
        endcase
    end
endmodule

// File: rtl/ilk_pend_track.sv
// Pending-result tracker: one entry per register holding the producer
// class and its age in cycles since issue. An age of 1 means the producer
// issued on the previous edge. An entry drops once its age passes the
// largest distance any class can need. A new write replaces an old entry.
// Assumes the caller never writes index 0.
module ilk_pend_track
    import ilk_pkg::*;
#(
    parameter int N   = NREG,
    parameter int IDW = REG_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [IDW-1:0]             wr_idx,
    input  logic [CLS_W-1:0]           wr_cls,
    output logic [N-1:0]               pend_v,
    output logic [N-1:0][CLS_W-1:0]    pend_cls,
    output logic [N-1:0][AGE_W-1:0]    pend_age
);
    for (genvar r = 0; r < N; r++) begin : g_ent
        logic hit;
        assign hit = wr_en && (wr_idx == IDW'(r));

        // Entry r: load on write, otherwise age and retire.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_v[r]   <= 1'b0;
                pend_cls[r] <= '0;
                pend_age[r] <= '0;
            end else if (hit) begin
                pend_v[r]   <= 1'b1;
                pend_cls[r] <= wr_cls;
                pend_age[r] <= AGE_W'(1);
            end else if (pend_v[r]) begin
                if (pend_age[r] >= AGE_W'(MAX_GAP)) begin
                    pend_v[r] <= 1'b0;
                end else begin
                    pend_age[r] <= pend_age[r] + AGE_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/ilk_src_check.sv
// Source hazard check: looks up the pending entry for one source register
// and reports whether the required distance has not yet passed.
// Index 0 and unused sources never block.
module ilk_src_check
    import ilk_pkg::*;
#(
    parameter int N   = NREG,
    parameter int IDW = REG_W
) (
    input  logic                    src_v,
    input  logic [IDW-1:0]          src_idx,
    input  logic                    store_data,
    input  logic [N-1:0]            pend_v,
    input  logic [N-1:0][CLS_W-1:0] pend_cls,
    input  logic [N-1:0][AGE_W-1:0] pend_age,
    output logic                    blocked
);
    logic [AGE_W-1:0] need;
    logic             live;

    ilk_gap_lut u_lut (
        .prod_cls   (pend_cls[src_idx]),
        .store_data (store_data),
        .gap        (need)
    );

    // The source counts only when used, nonzero and tracked.
    always_comb live = src_v && (src_idx != '0) && pend_v[src_idx];

    // Block while the age has not yet exceeded the required distance.
    always_comb blocked = live && (pend_age[src_idx] <= need);
endmodule

// File: rtl/ilk_issue_top.sv
// In-order issue interlock: issues the presented instruction when no
// source is blocked, and otherwise stalls it (one bubble per cycle).
// Assumes upstream holds the instruction stable while stall is high.
module ilk_issue_top
    import ilk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [2:0]       in_class,
    input  logic [5:0]       in_dst,
    input  logic             in_dst_we,
    input  logic [5:0]       in_src0,
    input  logic             in_src0_v,
    input  logic [5:0]       in_src1,
    input  logic             in_src1_v,
    output logic             issue,
    output logic             stall
);
    localparam int NSRC = 2;

    logic [NREG-1:0]            pend_v;
    logic [NREG-1:0][CLS_W-1:0] pend_cls;
    logic [NREG-1:0][AGE_W-1:0] pend_age;
    logic [NSRC-1:0]            blk;
    logic [NSRC-1:0][REG_W-1:0] s_idx;
    logic [NSRC-1:0]            s_v;
    logic                       hazard;
    logic                       wr_en;

    assign s_idx = {in_src1, in_src0};
    assign s_v   = {in_src1_v, in_src0_v};

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        logic sd;
        // Only src1 of a store is the data operand.
        assign sd = (s == 1) && (in_class == CL_FP_ST);
        ilk_src_check u_chk (
            .src_v      (s_v[s]),
            .src_idx    (s_idx[s]),
            .store_data (sd),
            .pend_v     (pend_v),
            .pend_cls   (pend_cls),
            .pend_age   (pend_age),
            .blocked    (blk[s])
        );
    end

    // Combine the source checks into the issue decision.
    always_comb begin
        hazard = |blk;
        issue  = in_valid && !hazard;
        stall  = in_valid && hazard;
    end

    // Record a result only for an issued, writing class with a nonzero target.
    always_comb wr_en = issue && in_dst_we && cls_writes(in_class) && (in_dst != '0);

    ilk_pend_track u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (in_dst),
        .wr_cls   (in_class),
        .pend_v   (pend_v),
        .pend_cls (pend_cls),
        .pend_age (pend_age)
    );
endmodule

// File: rtl/ilk_issue_chk.sv
// Checker for the issue interlock, bound to every ilk_issue_top instance.
module ilk_issue_chk
    import ilk_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [2:0] in_class,
    input logic [5:0] in_dst,
    input logic       in_dst_we,
    input logic [5:0] in_src0,
    input logic       in_src0_v,
    input logic       in_src1_v,
    input logic       issue,
    input logic       stall
);
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue && stall));

    a_r8_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (issue || stall) |-> in_valid);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> (!issue && !stall));

    a_r7_no_sources: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_src0_v && !in_src1_v) |-> issue);

    a_r2_fp_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && in_class == CL_FP_ALU && in_dst_we && in_dst != 6'd0) |=>
        !(issue && in_class == CL_FP_ALU && in_src0_v && in_src0 == $past(in_dst)));
endmodule

bind ilk_issue_top ilk_issue_chk u_issue_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_class  (in_class),
    .in_dst    (in_dst),
    .in_dst_we (in_dst_we),
    .in_src0   (in_src0),
    .in_src0_v (in_src0_v),
    .in_src1_v (in_src1_v),
    .issue     (issue),
    .stall     (stall)
);

// File: tb/tb_ilk_issue_top.sv
`timescale 1ns/1ps
module tb_ilk_issue_top;
    localparam logic [2:0] IA = 3'd0, IL = 3'd1, FA = 3'd2, FL = 3'd3, FS = 3'd4, BR = 3'd5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_dst_we = 1'b0, in_src0_v = 1'b0, in_src1_v = 1'b0;
    logic [2:0] in_class = 3'd0;
    logic [5:0] in_dst = 6'd0, in_src0 = 6'd0, in_src1 = 6'd0;
    logic issue, stall;
    int checks = 0, fails = 0;
    int cyc = 0;
    bit done = 0;

    // model state: issue cycle and class of the last producer per register
    int  m_cyc [64];
    int  m_cls [64];
    bit  m_on  [64];
    int  m_now;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ilk_issue_top dut (.*);

    function automatic int fpreg(input int n); return 32 + n; endfunction

    function automatic int ref_gap(input int pc, input bit sd);
        case (pc)
            2: return sd ? 2 : 3;
            3: return sd ? 0 : 1;
            1: return 1;
            default: return 0;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int r = 0; r < 64; r++) m_on[r] = 0;
        m_now = 0;
    endtask

    // Model: stalls for an instruction presented right after the last one.
    task automatic model_step(input logic [2:0] c, input int d, input bit we,
                              input int s0, input bit v0, input int s1, input bit v1,
                              output int st);
        int req = m_now;
        int srcs[2] = '{s0, s1};
        bit vs[2] = '{v0, v1};
        for (int k = 0; k < 2; k++) begin
            if (vs[k] && srcs[k] != 0 && m_on[srcs[k]]) begin
                int t = m_cyc[srcs[k]] + ref_gap(m_cls[srcs[k]], k == 1 && c == FS) + 1;
                if (t > req) req = t;
            end
        end
        st = req - m_now;
        if (we && d != 0 && c inside {IA, IL, FA, FL}) begin
            m_on[d] = 1; m_cyc[d] = req; m_cls[d] = c;
        end
        m_now = req + 1;
    endtask

    // Present one instruction at a negedge and count stall cycles until it issues.
    task automatic send(input logic [2:0] c, input int d, input bit we,
                        input int s0, input bit v0, input int s1, input bit v1,
                        output int st);
        bit held_ok = 1;
        st = 0;
        in_valid = 1; in_class = c; in_dst = 6'(d); in_dst_we = we;
        in_src0 = 6'(s0); in_src0_v = v0; in_src1 = 6'(s1); in_src1_v = v1;
        forever begin
            #1;
            if (issue && !stall) break;
            if (!(stall && !issue)) held_ok = 0;
            st++;
            if (st > 16) break;
            @(negedge clk);
        end
        @(negedge clk);
        in_valid = 0;
        if (!held_ok) check(0, "R8", 0, 1);
    endtask

    task automatic idle(input int n);
        in_valid = 0;
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_st(input logic [2:0] c, input int d, input bit we,
                             input int s0, input bit v0, input int s1, input bit v1,
                             input int exp, input string req);
        int st;
        send(c, d, we, s0, v0, s1, v1, st);
        check(st == exp, req, st, exp);
    endtask

    task automatic t_reset();
        #1;
        check(!issue && !stall, "R1", {issue, stall}, 0);
        expect_st(FA, fpreg(4), 1, fpreg(0), 1, fpreg(2), 1, 0, "R1");
        idle(4);
    endtask

    task automatic t_fp_chain();
        expect_st(FA, fpreg(4), 1, fpreg(0), 1, fpreg(2), 1, 0, "R2");
        expect_st(FA, fpreg(6), 1, fpreg(4), 1, fpreg(2), 1, 3, "R2");
        idle(2);
        expect_st(FA, fpreg(7), 1, fpreg(2), 1, fpreg(6), 1, 1, "R2");
        idle(3);
        expect_st(FA, fpreg(9), 1, fpreg(7), 1, 0, 0, 0, "R2");
        idle(4);
    endtask

    task automatic t_store_data();
        expect_st(FA, fpreg(8), 1, fpreg(0), 1, 0, 0, 0, "R3");
        expect_st(FS, 0, 0, 1, 1, fpreg(8), 1, 2, "R3");
        idle(4);
        expect_st(FA, fpreg(8), 1, fpreg(0), 1, 0, 0, 0, "R3");
        expect_st(FS, 0, 0, fpreg(8), 1, 0, 0, 3, "R3");
        idle(4);
    endtask

    task automatic t_loads();
        expect_st(FL, fpreg(0), 1, 1, 1, 0, 0, 0, "R4");
        expect_st(FA, fpreg(4), 1, fpreg(0), 1, fpreg(2), 1, 1, "R4");
        idle(4);
        expect_st(FL, fpreg(10), 1, 1, 1, 0, 0, 0, "R5");
        expect_st(FS, 0, 0, 1, 1, fpreg(10), 1, 0, "R5");
        idle(4);
        expect_st(IL, 2, 1, 6, 1, 0, 0, 0, "R6");
        expect_st(IA, 4, 1, 2, 1, 7, 1, 1, "R6");
        expect_st(IA, 3, 1, 4, 1, 0, 0, 0, "R6");
        expect_st(BR, 0, 0, 3, 1, 0, 0, 0, "R6");
        idle(4);
    endtask

    task automatic t_ignored();
        expect_st(IL, 0, 1, 6, 1, 0, 0, 0, "R7");
        expect_st(IA, 5, 1, 0, 1, 0, 1, 0, "R7");
        expect_st(FA, fpreg(5), 1, fpreg(1), 1, 0, 0, 0, "R7");
        expect_st(FA, fpreg(11), 1, fpreg(5), 0, fpreg(5), 0, 0, "R7");
        idle(4);
        expect_st(FS, fpreg(13), 1, 1, 1, fpreg(2), 1, 0, "R10");
        expect_st(FA, fpreg(1), 1, fpreg(13), 1, 0, 0, 0, "R10");
        idle(4);
        expect_st(FA, fpreg(14), 0, fpreg(2), 1, 0, 0, 0, "R10");
        expect_st(FA, fpreg(1), 1, fpreg(14), 1, 0, 0, 0, "R10");
        idle(4);
    endtask

    task automatic t_replace();
        expect_st(FA, fpreg(12), 1, fpreg(2), 1, 0, 0, 0, "R9");
        expect_st(FL, fpreg(12), 1, 1, 1, 0, 0, 0, "R9");
        expect_st(FA, fpreg(3), 1, fpreg(12), 1, 0, 0, 1, "R9");
        idle(4);
    endtask

    task automatic run_loop(input bit sched, input int iters, output int dut_st, output int mod_st);
        int st, ms;
        dut_st = 0; mod_st = 0;
        model_clear();
        for (int it = 0; it < iters; it++) begin
            if (!sched) begin
                send(FL, fpreg(0), 1, 1, 1, 0, 0, st); model_step(FL, fpreg(0), 1, 1, 1, 0, 0, ms); dut_st += st; mod_st += ms;
                send(FA, fpreg(4), 1, fpreg(0), 1, fpreg(2), 1, st); model_step(FA, fpreg(4), 1, fpreg(0), 1, fpreg(2), 1, ms); dut_st += st; mod_st += ms;
                send(FS, 0, 0, 1, 1, fpreg(4), 1, st); model_step(FS, 0, 0, 1, 1, fpreg(4), 1, ms); dut_st += st; mod_st += ms;
                send(IA, 1, 1, 1, 1, 0, 0, st); model_step(IA, 1, 1, 1, 1, 0, 0, ms); dut_st += st; mod_st += ms;
                send(BR, 0, 0, 1, 1, 0, 0, st); model_step(BR, 0, 0, 1, 1, 0, 0, ms); dut_st += st; mod_st += ms;
            end else begin
                for (int k = 0; k < 4; k++) begin
                    send(FL, fpreg(4*k+2+(k==0?-2:0)), 1, 1, 1, 0, 0, st);
                    model_step(FL, fpreg(4*k+2+(k==0?-2:0)), 1, 1, 1, 0, 0, ms); dut_st += st; mod_st += ms;
                end
                for (int k = 0; k < 4; k++) begin
                    send(FA, fpreg(4*k+4), 1, fpreg(4*k+2+(k==0?-2:0)), 1, fpreg(2), 1, st);
                    model_step(FA, fpreg(4*k+4), 1, fpreg(4*k+2+(k==0?-2:0)), 1, fpreg(2), 1, ms); dut_st += st; mod_st += ms;
                end
                for (int k = 0; k < 3; k++) begin
                    send(FS, 0, 0, 1, 1, fpreg(4*k+4), 1, st);
                    model_step(FS, 0, 0, 1, 1, fpreg(4*k+4), 1, ms); dut_st += st; mod_st += ms;
                end
                send(IA, 1, 1, 1, 1, 0, 0, st); model_step(IA, 1, 1, 1, 1, 0, 0, ms); dut_st += st; mod_st += ms;
                send(BR, 0, 0, 1, 1, 0, 0, st); model_step(BR, 0, 0, 1, 1, 0, 0, ms); dut_st += st; mod_st += ms;
                send(FS, 0, 0, 1, 1, fpreg(16), 1, st); model_step(FS, 0, 0, 1, 1, fpreg(16), 1, ms); dut_st += st; mod_st += ms;
            end
        end
        idle(4);
    endtask

    task automatic t_loops();
        int d, m;
        run_loop(0, 3, d, m);
        check(d == m, "R11", d, m);
        check(d == 9, "R11", d, 9);
        run_loop(1, 3, d, m);
        check(d == m, "R11", d, m);
        check(d == 0, "R11", d, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_fp_chain();
        t_store_data();
        t_loads();
        t_ignored();
        t_replace();
        t_loops();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        wait (cyc > 50000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 50000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule